// File: doc/BRIEF.md
# RTC Event and Interrupt Unit

This block sits beside a real-time-clock time keeper and turns its once-per-second tick into per-event status flags. The time keeper supplies the packed time word and a one-cycle tick pulse. The pulse arrives in the same clock cycle in which the word already shows the new second. On each tick the unit raises a seconds flag. It raises minute, hour and day flags when those fields roll over to zero. It also compares the word against an alarm word in two ways. One compare checks the time of day only. The other checks the full word, day included.

A 16-bit stopwatch counts down once per tick. It raises its own flag when it reaches zero. Status flags are write-one-to-clear, and a clear takes effect at the next clock edge. A clear does not wait for any one-second write synchronisation. The interrupt output combines the flags with a separate enable mask, so firmware can pick which events interrupt it and poll for the others.

Top module: `rtc_event_unit`

## Requirements
- R1: After reset, all status flags, all enable bits and the stopwatch count are zero, and `irq` is low.
- R2: A clear write with bit i of `clr_data` set drives status bit i to 0 at the next clock edge, and status bits whose clear bit is 0 keep their value.
- R3: Every tick sets the seconds flag, status bit 2.
- R4: The time word is packed as seconds [5:0], minutes [11:6], hours [16:12] and day [31:17]. On a tick where the seconds field is 0, the minute flag (bit 3) is set. When seconds and minutes are both 0, the hour flag (bit 4) is also set. When seconds, minutes and hours are all 0, the day flag (bit 5) is also set.
- R5: On a tick where the seconds, minutes and hours of the time word equal those of `alarm_word`, the time-of-day alarm flag (bit 1) is set, whatever either day field holds.
- R6: On a tick where the whole time word equals `alarm_word`, the day alarm flag (bit 6) is set. A mismatch in the day field alone keeps bit 6 clear.
- R7: A nonzero stopwatch count decreases by one on each tick. The tick that takes it from 1 to 0 sets the stopwatch flag (bit 0).
- R8: A count of zero stays at zero and never sets bit 0. This covers both a count that has run out and one loaded as zero.
- R9: A stopwatch load in the same cycle as a tick wins: the count becomes the loaded value, with no decrement.
- R10: `irq` is high exactly when some status bit is set together with the enable bit at the same position. An enable write replaces the whole mask.
- R11: When an event and a clear hit the same status bit in one cycle, the event wins and the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 1 Hz pulse; `time_now` already holds the new second |
| time_now | input | 32 | Packed current time word |
| alarm_word | input | 32 | Packed alarm word, same layout |
| sw_load | input | 1 | Load the stopwatch count |
| sw_load_val | input | 16 | Stopwatch value to load |
| en_wr | input | 1 | Write the interrupt enable mask |
| en_wdata | input | 7 | New enable mask |
| clr_wr | input | 1 | Write-one-to-clear strobe for status |
| clr_data | input | 7 | Status bits to clear |
| status | output | 7 | Event status flags |
| irq | output | 1 | Interrupt request |
| sw_count | output | 16 | Current stopwatch count |

## Verification
The assertions check on every cycle that flags change only on a tick or a clear, and that a tick always leaves the seconds flag set. They also check that a clear takes effect at once, that the stopwatch stays still between ticks and stays at zero, that the stopwatch flag follows the 1-to-0 step, and that `irq` stays low while no flag is set. Some behaviour depends on particular time and alarm values, so only the bench scenarios can show it. This covers which rollover flags go up together, and how the time-of-day alarm differs from the day alarm. The bench also shows the count running down over several ticks, load priority, and how the enable mask steers `irq`.

// File: rtl/rtc_ev_pkg.sv
package rtc_ev_pkg;
   localparam int NEV     = 7;
   localparam int EV_SW   = 0;
   localparam int EV_ALM  = 1;
   localparam int EV_SEC  = 2;
   localparam int EV_MIN  = 3;
   localparam int EV_HOUR = 4;
   localparam int EV_DAY  = 5;
   localparam int EV_DALM = 6;
endpackage

// File: rtl/rtc_ev_detect.sv
module rtc_ev_detect
   import rtc_ev_pkg::*;
#(
   parameter int SEC_W  = 6,
   parameter int MIN_W  = 6,
   parameter int HOUR_W = 5,
   parameter int DAY_W  = 15,
   parameter bit DAY_ALARM_EN = 1'b1,
   localparam int HMS_W = SEC_W + MIN_W + HOUR_W,
   localparam int TW    = HMS_W + DAY_W
) (
   input  logic          tick,
   input  logic [TW-1:0] time_now,
   input  logic [TW-1:0] alarm_word,
   output logic [NEV-1:0] ev
);
   logic sec_zero, min_zero, hour_zero, hms_match, full_match;

   assign sec_zero  = (time_now[SEC_W-1:0] == '0);
   assign min_zero  = (time_now[SEC_W +: MIN_W] == '0);
   assign hour_zero = (time_now[SEC_W+MIN_W +: HOUR_W] == '0);
   assign hms_match = (time_now[HMS_W-1:0] == alarm_word[HMS_W-1:0]);

   // the day compare exists only when the variant asks for it
   if (DAY_ALARM_EN) begin : g_dalm
      assign full_match = (time_now == alarm_word);
   end else begin : g_no_dalm
      assign full_match = 1'b0;
   end

   always_comb begin
      ev          = '0;
      ev[EV_SEC]  = tick;
      ev[EV_MIN]  = tick && sec_zero;
      ev[EV_HOUR] = tick && sec_zero && min_zero;
      ev[EV_DAY]  = tick && sec_zero && min_zero && hour_zero;
      ev[EV_ALM]  = tick && hms_match;
      ev[EV_DALM] = tick && full_match;
   end
endmodule

// File: rtl/rtc_ev_stopwatch.sv
module rtc_ev_stopwatch #(
   parameter int SW_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            load,
   input  logic [SW_W-1:0] load_val,
   output logic [SW_W-1:0] count,
   output logic            expire
);
   localparam logic [SW_W-1:0] ONE = SW_W'(1);

   logic [SW_W-1:0] cnt_q;

   // expiry is the tick that steps 1 -> 0; a load in the same cycle overrides
   assign expire = tick && !load && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (tick && (cnt_q != '0))
         cnt_q <= cnt_q - ONE;
   end

   assign count = cnt_q;
endmodule

// File: rtl/rtc_ev_status.sv
module rtc_ev_status #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_ev,
   input  logic         clr_wr,
   input  logic [N-1:0] clr_data,
   input  logic         en_wr,
   input  logic [N-1:0] en_wdata,
   output logic [N-1:0] status,
   output logic         irq
);
   logic [N-1:0] st_q;
   logic [N-1:0] en_q;

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            st_q[i] <= 1'b0;
         else if (set_ev[i])
            st_q[i] <= 1'b1;
         else if (clr_wr && clr_data[i])
            st_q[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (en_wr)
         en_q <= en_wdata;
   end

   assign status = st_q;
   assign irq    = |(st_q & en_q);
endmodule

// File: rtl/rtc_event_unit.sv
module rtc_event_unit
   import rtc_ev_pkg::*;
#(
   parameter int SEC_W  = 6,
   parameter int MIN_W  = 6,
   parameter int HOUR_W = 5,
   parameter int DAY_W  = 15,
   parameter int SW_W   = 16,
   parameter bit DAY_ALARM_EN = 1'b1,
   localparam int TW = SEC_W + MIN_W + HOUR_W + DAY_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [TW-1:0]   time_now,
   input  logic [TW-1:0]   alarm_word,
   input  logic            sw_load,
   input  logic [SW_W-1:0] sw_load_val,
   input  logic            en_wr,
   input  logic [NEV-1:0]  en_wdata,
   input  logic            clr_wr,
   input  logic [NEV-1:0]  clr_data,
   output logic [NEV-1:0]  status,
   output logic            irq,
   output logic [SW_W-1:0] sw_count
);
   if (TW > 64) begin : g_bad_tw
      $error("rtc_event_unit: time word wider than 64 bits");
   end
   if (SW_W < 2) begin : g_bad_sw
      $error("rtc_event_unit: stopwatch needs at least 2 bits");
   end

   logic [NEV-1:0] det_ev;
   logic [NEV-1:0] set_ev;
   logic           sw_exp;

   rtc_ev_detect #(
      .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W),
      .DAY_ALARM_EN(DAY_ALARM_EN)
   ) u_det (
      .tick(tick), .time_now(time_now), .alarm_word(alarm_word), .ev(det_ev)
   );

   rtc_ev_stopwatch #(.SW_W(SW_W)) u_sw (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(sw_load),
      .load_val(sw_load_val), .count(sw_count), .expire(sw_exp)
   );

   always_comb begin
      set_ev        = det_ev;
      set_ev[EV_SW] = sw_exp;
   end

   rtc_ev_status #(.N(NEV)) u_st (
      .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_wr(clr_wr),
      .clr_data(clr_data), .en_wr(en_wr), .en_wdata(en_wdata),
      .status(status), .irq(irq)
   );
endmodule

// File: rtl/rtc_ev_chk.sv
module rtc_ev_chk
   import rtc_ev_pkg::*;
#(
   parameter int SW_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick,
   input logic            sw_load,
   input logic            clr_wr,
   input logic [NEV-1:0]  clr_data,
   input logic [NEV-1:0]  status,
   input logic            irq,
   input logic [SW_W-1:0] sw_count
);
   p_sec_every_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> status[EV_SEC]);

   p_clear_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_data[EV_SEC] && !tick) |=> !status[EV_SEC]);

   p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr_wr) |=> (status == $past(status)));

   p_sw_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !sw_load) |=> $stable(sw_count));

   p_sw_zero_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_count == '0 && !sw_load) |=> (sw_count == '0));

   p_sw_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !sw_load && sw_count == SW_W'(1)) |=> status[EV_SW]);

   p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> !irq);
endmodule

bind rtc_event_unit rtc_ev_chk #(.SW_W(SW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .sw_load(sw_load),
   .clr_wr(clr_wr), .clr_data(clr_data), .status(status), .irq(irq),
   .sw_count(sw_count)
);

// File: tb/tb_rtc_event_unit.sv
module tb_rtc_event_unit;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [31:0] time_now = '0;
   logic [31:0] alarm_word = '0;
   logic        sw_load = 1'b0;
   logic [15:0] sw_load_val = '0;
   logic        en_wr = 1'b0;
   logic [6:0]  en_wdata = '0;
   logic        clr_wr = 1'b0;
   logic [6:0]  clr_data = '0;
   logic [6:0]  status;
   logic        irq;
   logic [15:0] sw_count;

   int checks = 0;
   int errors = 0;

   always #(PERIOD/2) clk = ~clk;

   rtc_event_unit dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .time_now(time_now),
      .alarm_word(alarm_word), .sw_load(sw_load), .sw_load_val(sw_load_val),
      .en_wr(en_wr), .en_wdata(en_wdata), .clr_wr(clr_wr), .clr_data(clr_data),
      .status(status), .irq(irq), .sw_count(sw_count)
   );

   // {time word, alarm word, expected status after one tick from all-clear}
   localparam logic [70:0] VEC [7] = '{
      {{15'd0, 5'd1, 6'd2, 6'd3}, {15'd0, 5'd5, 6'd0, 6'd0}, 7'h04},
      {{15'd3, 5'd1, 6'd2, 6'd0}, {15'd0, 5'd5, 6'd0, 6'd0}, 7'h0C},
      {{15'd3, 5'd2, 6'd0, 6'd0}, {15'd0, 5'd5, 6'd0, 6'd0}, 7'h1C},
      {{15'd4, 5'd0, 6'd0, 6'd0}, {15'd0, 5'd5, 6'd0, 6'd0}, 7'h3C},
      {{15'd7, 5'd5, 6'd6, 6'd7}, {15'd2, 5'd5, 6'd6, 6'd7}, 7'h06},
      {{15'd2, 5'd5, 6'd6, 6'd7}, {15'd2, 5'd5, 6'd6, 6'd7}, 7'h46},
      {{15'd2, 5'd0, 6'd0, 6'd0}, {15'd2, 5'd0, 6'd0, 6'd0}, 7'h7E}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic clear(input logic [6:0] m);
      clr_wr = 1'b1; clr_data = m;
      @(negedge clk);
      clr_wr = 1'b0; clr_data = '0;
   endtask

   task automatic load_sw(input logic [15:0] v);
      sw_load = 1'b1; sw_load_val = v;
      @(negedge clk);
      sw_load = 1'b0;
   endtask

   task automatic write_en(input logic [6:0] m);
      en_wr = 1'b1; en_wdata = m;
      @(negedge clk);
      en_wr = 1'b0;
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 status", {25'd0, status}, 32'h0);
      check("R1 irq", {31'd0, irq}, 32'h0);
      check("R1 count", {16'd0, sw_count}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R3 R4 R5 R6
      for (int i = 0; i < 7; i++) begin
         clear(7'h7F);
         time_now   = VEC[i][70:39];
         alarm_word = VEC[i][38:7];
         do_tick();
         check($sformatf("R3/R4/R5/R6 vec%0d", i), {25'd0, status}, {25'd0, VEC[i][6:0]});
      end

      // R2: clear one flag, others stay (status is 7E here)
      clear(7'h04);
      check("R2 partial clear", {25'd0, status}, 32'h7A);

      // R11: event beats clear in the same cycle
      time_now = {15'd1, 5'd3, 6'd4, 6'd5};
      clr_wr = 1'b1; clr_data = 7'h04;
      do_tick();
      clr_wr = 1'b0; clr_data = '0;
      check("R11 set wins", {31'd0, status[2]}, 32'h1);

      // R10 interrupt masking
      clear(7'h7F);
      do_tick();
      check("R10 masked", {31'd0, irq}, 32'h0);
      write_en(7'h04);
      check("R10 enabled", {31'd0, irq}, 32'h1);
      write_en(7'h08);
      check("R10 mask replaced", {31'd0, irq}, 32'h0);
      write_en(7'h04);
      clear(7'h04);
      check("R10 cleared", {31'd0, irq}, 32'h0);

      // R7 stopwatch run-down
      clear(7'h7F);
      load_sw(16'd3);
      check("R7 loaded", {16'd0, sw_count}, 32'd3);
      do_tick();
      do_tick();
      check("R7 count 1", {16'd0, sw_count}, 32'd1);
      check("R7 no early flag", {31'd0, status[0]}, 32'h0);
      do_tick();
      check("R7 count 0", {16'd0, sw_count}, 32'd0);
      check("R7 flag", {31'd0, status[0]}, 32'h1);

      // R8 no repeat at zero
      clear(7'h01);
      do_tick();
      do_tick();
      check("R8 no repeat", {31'd0, status[0]}, 32'h0);
      check("R8 held zero", {16'd0, sw_count}, 32'd0);

      // R9 load beats tick
      sw_load = 1'b1; sw_load_val = 16'd5;
      do_tick();
      sw_load = 1'b0;
      check("R9 load priority", {16'd0, sw_count}, 32'd5);

      // R8 zero load disables
      load_sw(16'd0);
      clear(7'h7F);
      do_tick();
      do_tick();
      do_tick();
      check("R8 zero load", {31'd0, status[0]}, 32'h0);
      check("R8 zero load count", {16'd0, sw_count}, 32'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule